// File: doc/BRIEF.md
# Compatibility Palette ID Selector

This block reads a cartridge header through a one-byte read port and works out an 8-bit palette ID. That ID later picks the colours used to show a monochrome-only title on a colour display. The block runs as a state machine. It moves through the states ST_IDLE, ST_OLD_LIC, ST_NEW_HI, ST_NEW_LO, ST_TITLE, ST_GATE, ST_TAB_SCAN, ST_LTR_SCAN and ST_DONE.

A `start` pulse in ST_IDLE clears the running sum and moves to ST_OLD_LIC, which fetches the old licensee byte. If that byte is $33, the machine goes to ST_NEW_HI and then ST_NEW_LO to check the two-byte new code. In ST_NEW_HI a mismatch skips straight to ST_TITLE. Otherwise the old byte alone decides, and the machine moves to ST_TITLE. ST_TITLE takes sixteen cycles to add up the title bytes and to capture the fourth letter. From there the machine moves to ST_GATE.

ST_GATE ends the run with ID $00 if the licensee check failed. Otherwise it starts a linear search of a parameter table of title checksums and moves to ST_TAB_SCAN. ST_TAB_SCAN finishes in any of these cases:
- there is no hit;
- the hit index is small enough to be used directly.

Otherwise it starts a search of the letter table and moves to ST_LTR_SCAN. ST_LTR_SCAN turns the matching row into an offset. Every run ends in ST_DONE, which pulses `done` and returns to ST_IDLE.

The block also raises a flag that asks software or later hardware to write the logo tilemap. It does this for two particular IDs.

Top module: `pal_id_sel`

## Requirements
- R1: While `rst` is high and after it, until the first run completes, `pal_id`, `title_sum`, `logo_req` and `done` are all zero.
- R2: The licensee passes in exactly two cases. The first is that the byte at $014B is $01. The second is that the byte at $014B is $33, the byte at $0144 is $30 and the byte at $0145 is $31. In every other case `pal_id` is $00.
- R3: `title_sum` is the modulo-256 sum of the sixteen bytes at $0134-$0143. It holds that sum when `done` pulses, whether or not the licensee passed.
- R4: When the licensee passes and no checksum table entry among the first `CSUM_N` equals `title_sum`, `pal_id` is $00.
- R5: When the first matching checksum entry has index i and i <= `DIRECT_MAX` (64), `pal_id` is i.
- R6: When i > `DIRECT_MAX`, the byte at $0137 is searched in the letter table. The table holds `LTR_ROWS` rows of `LTR_COLS` entries each, stored row after row. The search stops at the first matching position k. If a match exists, `pal_id` = i + `ROW_STEP` * (k / `LTR_COLS`) with `ROW_STEP` = 14. If no entry matches, `pal_id` is $00.
- R7: When `done` is high, `logo_req` is 1 exactly when `pal_id` is $43 or $58.
- R8: Every accepted `start` gives exactly one one-cycle `done` pulse. `pal_id` and `logo_req` change only in the cycle where `done` is high.
- R9: A `start` pulse while a run is in progress has no effect. The run finishes with the result it would have had without that pulse, and no extra `done` pulse appears.
- R10: `hdr_addr` always lies within $0134-$014B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when the block is idle |
| hdr_addr | output | 16 | Header byte address being read |
| hdr_rdata | input | 8 | Header byte at `hdr_addr`, valid in the same cycle |
| pal_id | output | 8 | Selected palette ID |
| title_sum | output | 8 | Sum of the sixteen title bytes |
| logo_req | output | 1 | Request to write the logo tilemap |
| done | output | 1 | One-cycle pulse when a run completes |

## Verification
The checker assumes that `hdr_rdata` reflects `hdr_addr` combinationally in the same cycle. It also assumes that `start` is a single-cycle pulse. The bench models the header as an array that is read without delay, and it raises `start` for one cycle only. It gives a second pulse only in the cases that are meant to be ignored. The bench supplies its own checksum and letter tables, which have known duplicates and known missing letters. It then sweeps all 256 title sums and every letter from A to Z against the indices above 64, so every path through the searches is exercised.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int TAB_CAP   = 96;
    localparam int TITLE_LEN = 16;

    localparam logic [15:0] HDR_TITLE   = 16'h0134;
    localparam logic [15:0] HDR_LETTER  = 16'h0137;
    localparam logic [15:0] HDR_NEW_HI  = 16'h0144;
    localparam logic [15:0] HDR_NEW_LO  = 16'h0145;
    localparam logic [15:0] HDR_OLD_LIC = 16'h014B;

    localparam logic [7:0] OLD_USE_NEW = 8'h33;
    localparam logic [7:0] OLD_OK      = 8'h01;
    localparam logic [7:0] NEW_HI_OK   = 8'h30;
    localparam logic [7:0] NEW_LO_OK   = 8'h31;
    localparam logic [7:0] LOGO_ID_A   = 8'h43;
    localparam logic [7:0] LOGO_ID_B   = 8'h58;

    typedef logic [0:TAB_CAP-1][7:0] tab_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_OLD_LIC, ST_NEW_HI, ST_NEW_LO, ST_TITLE,
        ST_GATE, ST_TAB_SCAN, ST_LTR_SCAN, ST_DONE
    } sel_state_t;

    function automatic tab_t default_csum_tab();
        tab_t t;
        for (int i = 0; i < TAB_CAP; i++) t[i] = 8'((i * 37 + 11) % 256);
        return t;
    endfunction

    function automatic tab_t default_ltr_tab();
        tab_t t;
        for (int i = 0; i < TAB_CAP; i++) t[i] = 8'(65 + (i * 7) % 23);
        return t;
    endfunction
endpackage

// File: rtl/pal_sum_acc.sv
module pal_sum_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] sum_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) sum_o <= '0;
        else if (en_i)    sum_o <= sum_o + din_i;
    end
endmodule

// File: rtl/pal_lin_search.sv
module pal_lin_search #(
    parameter int DEPTH    = 80,
    parameter int ROW_LEN  = 80,
    parameter bit ROW_MODE = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [7:0]            key_i,
    input  logic [DEPTH-1:0][7:0] tab_i,
    output logic                  end_o,
    output logic                  hit_o,
    output logic [7:0]            loc_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic          busy_q;
    logic [7:0]    key_q;
    logic [PW-1:0] pos_q;
    logic          last;

    assign last  = (pos_q == PW'(DEPTH - 1));
    assign hit_o = busy_q && (tab_i[pos_q] == key_q);
    assign end_o = busy_q && (hit_o || last);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            key_q  <= '0;
            pos_q  <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            key_q  <= key_i;
            pos_q  <= '0;
        end else if (end_o) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            pos_q  <= pos_q + 1'b1;
        end
    end

    generate
        if (ROW_MODE) begin : g_row
            localparam int NROWS = (DEPTH + ROW_LEN - 1) / ROW_LEN;
            localparam int CW    = (ROW_LEN > 1) ? $clog2(ROW_LEN) : 1;
            localparam int RW    = (NROWS > 1) ? $clog2(NROWS) : 1;
            logic [CW-1:0] col_q;
            logic [RW-1:0] row_q;
            always_ff @(posedge clk) begin
                if (rst || start_i) begin
                    col_q <= '0;
                    row_q <= '0;
                end else if (busy_q && !end_o) begin
                    if (col_q == CW'(ROW_LEN - 1)) begin
                        col_q <= '0;
                        row_q <= row_q + 1'b1;
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
            end
            assign loc_o = 8'(row_q);
        end else begin : g_pos
            assign loc_o = 8'(pos_q);
        end
    endgenerate
endmodule

// File: rtl/pal_id_sel.sv
module pal_id_sel
    import pal_pkg::*;
#(
    parameter int   CSUM_N     = 80,
    parameter int   LTR_ROWS   = 4,
    parameter int   LTR_COLS   = 14,
    parameter int   ROW_STEP   = 14,
    parameter int   DIRECT_MAX = 64,
    parameter tab_t CSUM_TAB   = default_csum_tab(),
    parameter tab_t LTR_TAB    = default_ltr_tab()
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic [15:0] hdr_addr,
    input  logic [7:0]  hdr_rdata,
    output logic [7:0]  pal_id,
    output logic [7:0]  title_sum,
    output logic        logo_req,
    output logic        done
);
    localparam int          LTR_N      = LTR_ROWS * LTR_COLS;
    localparam int          CNT_W      = $clog2(TITLE_LEN);
    localparam logic [CNT_W-1:0] LETTER_POS = CNT_W'(HDR_LETTER - HDR_TITLE);
    localparam logic [CNT_W-1:0] CNT_LAST   = CNT_W'(TITLE_LEN - 1);

    sel_state_t state, state_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             lic_ok_q;
    logic [7:0]       letter_q, idx_q, id_nxt;
    logic             finish, c_start, l_start;
    logic             c_end, c_hit, l_end, l_hit;
    logic [7:0]       c_loc, l_loc;

    logic [CSUM_N-1:0][7:0] csum_tab;
    logic [LTR_N-1:0][7:0]  ltr_tab;

    genvar gi;
    generate
        for (gi = 0; gi < CSUM_N; gi++) begin : g_ctab
            assign csum_tab[gi] = CSUM_TAB[gi];
        end
        for (gi = 0; gi < LTR_N; gi++) begin : g_ltab
            assign ltr_tab[gi] = LTR_TAB[gi];
        end
    endgenerate

    pal_sum_acc #(.W(8)) i_sum (
        .clk(clk), .rst(rst),
        .clr_i(state == ST_IDLE && start),
        .en_i(state == ST_TITLE),
        .din_i(hdr_rdata), .sum_o(title_sum)
    );

    pal_lin_search #(.DEPTH(CSUM_N), .ROW_LEN(CSUM_N), .ROW_MODE(1'b0)) i_csum_srch (
        .clk(clk), .rst(rst), .start_i(c_start), .key_i(title_sum),
        .tab_i(csum_tab), .end_o(c_end), .hit_o(c_hit), .loc_o(c_loc)
    );

    pal_lin_search #(.DEPTH(LTR_N), .ROW_LEN(LTR_COLS), .ROW_MODE(1'b1)) i_ltr_srch (
        .clk(clk), .rst(rst), .start_i(l_start), .key_i(letter_q),
        .tab_i(ltr_tab), .end_o(l_end), .hit_o(l_hit), .loc_o(l_loc)
    );

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        finish    = 1'b0;
        id_nxt    = 8'h00;
        c_start   = 1'b0;
        l_start   = 1'b0;
        hdr_addr  = HDR_OLD_LIC;
        unique case (state)
            ST_IDLE:     if (start) state_nxt = ST_OLD_LIC;
            ST_OLD_LIC:  state_nxt = (hdr_rdata == OLD_USE_NEW) ? ST_NEW_HI : ST_TITLE;
            ST_NEW_HI: begin
                hdr_addr  = HDR_NEW_HI;
                state_nxt = (hdr_rdata == NEW_HI_OK) ? ST_NEW_LO : ST_TITLE;
            end
            ST_NEW_LO: begin
                hdr_addr  = HDR_NEW_LO;
                state_nxt = ST_TITLE;
            end
            ST_TITLE: begin
                hdr_addr = HDR_TITLE + 16'(cnt_q);
                if (cnt_q == CNT_LAST) state_nxt = ST_GATE;
            end
            ST_GATE: begin
                if (lic_ok_q) begin
                    c_start   = 1'b1;
                    state_nxt = ST_TAB_SCAN;
                end else begin
                    finish    = 1'b1;
                    state_nxt = ST_DONE;
                end
            end
            ST_TAB_SCAN: begin
                if (c_end) begin
                    if (c_hit && c_loc > 8'(DIRECT_MAX)) begin
                        l_start   = 1'b1;
                        state_nxt = ST_LTR_SCAN;
                    end else begin
                        finish    = 1'b1;
                        id_nxt    = c_hit ? c_loc : 8'h00;
                        state_nxt = ST_DONE;
                    end
                end
            end
            ST_LTR_SCAN: begin
                if (l_end) begin
                    finish    = 1'b1;
                    id_nxt    = l_hit ? (idx_q + 8'(ROW_STEP) * l_loc) : 8'h00;
                    state_nxt = ST_DONE;
                end
            end
            ST_DONE:     state_nxt = ST_IDLE;
            default:     state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            lic_ok_q <= 1'b0;
            letter_q <= '0;
            idx_q    <= '0;
            pal_id   <= '0;
            logo_req <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE:     cnt_q    <= '0;
                ST_OLD_LIC:  lic_ok_q <= (hdr_rdata == OLD_OK);
                ST_NEW_HI:   lic_ok_q <= (hdr_rdata == NEW_HI_OK);
                ST_NEW_LO:   lic_ok_q <= (hdr_rdata == NEW_LO_OK);
                ST_TITLE: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LETTER_POS) letter_q <= hdr_rdata;
                end
                ST_TAB_SCAN: if (c_end) idx_q <= c_loc;
                default: ;
            endcase
            if (finish) begin
                pal_id   <= id_nxt;
                logo_req <= (id_nxt == LOGO_ID_A) || (id_nxt == LOGO_ID_B);
            end
        end
    end

    assign done = (state == ST_DONE);
endmodule

// File: rtl/pal_id_sel_chk.sv
module pal_id_sel_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] hdr_addr,
    input logic [7:0]  pal_id,
    input logic        logo_req,
    input logic        done
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_ID_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(pal_id)); // R8
    AST_LOGO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(logo_req)); // R8
    AST_LOGO_FLAG: assert property (@(posedge clk) disable iff (rst)
        done |-> (logo_req == (pal_id == 8'h43 || pal_id == 8'h58))); // R7
    AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (hdr_addr >= 16'h0134) && (hdr_addr <= 16'h014B)); // R10
endmodule

bind pal_id_sel pal_id_sel_chk i_pal_id_sel_chk (
    .clk(clk), .rst(rst), .hdr_addr(hdr_addr),
    .pal_id(pal_id), .logo_req(logo_req), .done(done)
);

// File: tb/test_pal_id_sel.sv
module test_pal_id_sel;
    localparam int CLK_PERIOD = 10;
    localparam int B_CSUM_N   = 80;
    localparam int B_ROWS     = 4;
    localparam int B_COLS     = 14;

    function automatic pal_pkg::tab_t bench_csum();
        pal_pkg::tab_t t;
        for (int i = 0; i < pal_pkg::TAB_CAP; i++) t[i] = 8'((i * 53 + 7) % 256);
        return t;
    endfunction

    // row r, column c holds 'A' + c + 3r : rows overlap, X..Z never present
    function automatic pal_pkg::tab_t bench_ltr();
        pal_pkg::tab_t t;
        for (int i = 0; i < pal_pkg::TAB_CAP; i++) t[i] = 8'(65 + ((i % B_COLS) + 3 * (i / B_COLS)) % 26);
        return t;
    endfunction

    localparam pal_pkg::tab_t B_CSUM = bench_csum();
    localparam pal_pkg::tab_t B_LTR  = bench_ltr();

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] hdr_addr;
    logic [7:0]  hdr_rdata;
    logic [7:0]  pal_id, title_sum;
    logic        logo_req, done;
    logic [7:0]  hdr [0:23];

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign hdr_rdata = (hdr_addr >= 16'h0134 && hdr_addr <= 16'h014B) ? hdr[hdr_addr - 16'h0134] : 8'hFF;

    pal_id_sel #(
        .CSUM_N(B_CSUM_N), .LTR_ROWS(B_ROWS), .LTR_COLS(B_COLS),
        .ROW_STEP(14), .DIRECT_MAX(64), .CSUM_TAB(B_CSUM), .LTR_TAB(B_LTR)
    ) i_pal_id_sel (
        .clk(clk), .rst(rst), .start(start), .hdr_addr(hdr_addr),
        .hdr_rdata(hdr_rdata), .pal_id(pal_id), .title_sum(title_sum),
        .logo_req(logo_req), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int model_id(input logic [7:0] ol, hi, lo, sum, ltr);
        int idx = -1;
        int k = -1;
        if (!((ol == 8'h01) || (ol == 8'h33 && hi == 8'h30 && lo == 8'h31))) return 0;  // R2
        for (int i = B_CSUM_N - 1; i >= 0; i--) if (B_CSUM[i] == sum) idx = i;           // R4
        if (idx < 0) return 0;
        if (idx <= 64) return idx;                                                       // R5
        for (int j = B_ROWS * B_COLS - 1; j >= 0; j--) if (B_LTR[j] == ltr) k = j;       // R6
        if (k < 0) return 0;
        return (idx + 14 * (k / B_COLS)) % 256;
    endfunction

    task automatic run_case(input logic [7:0] ol, hi, lo, sum, ltr,
                            input int seed, input bit poke, input string req);
        logic [7:0] rest = 8'h00;
        int exp_id, ndone, after;
        logic [7:0] got_id, got_sum;
        logic got_logo;
        for (int i = 0; i < 24; i++) hdr[i] = 8'(i * 29 + seed);
        for (int i = 1; i < 16; i++) begin
            if (i == 3) hdr[i] = ltr;
            else        hdr[i] = 8'(i * 13 + seed);
            rest = rest + hdr[i];
        end
        hdr[0]  = sum - rest;
        hdr[16] = hi;
        hdr[17] = lo;
        hdr[23] = ol;
        exp_id  = model_id(ol, hi, lo, sum, ltr);
        ndone = 0; after = 0; got_id = 0; got_sum = 0; got_logo = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int n = 0; n < 400; n++) begin
            start = (poke && n == 6);
            if (done) begin
                ndone++;
                if (ndone == 1) begin
                    got_id = pal_id; got_sum = title_sum; got_logo = logo_req;
                end
            end
            if (ndone > 0) after++;
            if (after > 4) break;
            @(negedge clk);
        end
        start = 1'b0;
        chk(ndone == 1, poke ? "R9" : "R8", "done pulses", ndone, 1);
        chk(got_id == 8'(exp_id), req, "pal_id", got_id, exp_id);
        chk(got_sum == sum, "R3", "title_sum", got_sum, sum);
        chk(got_logo == (exp_id == 'h43 || exp_id == 'h58), "R7", "logo_req", got_logo,
            (exp_id == 'h43 || exp_id == 'h58));
        chk(pal_id == got_id, "R8", "pal_id hold", pal_id, got_id);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 24; i++) hdr[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pal_id == 0 && title_sum == 0 && logo_req == 0 && done == 0, "R1", "reset outputs",
            {pal_id, title_sum, 6'd0, logo_req, done}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(pal_id == 0 && logo_req == 0 && done == 0, "R1", "idle after reset",
            {pal_id, 7'd0, logo_req}, 0);
        chk(hdr_addr >= 16'h0134 && hdr_addr <= 16'h014B, "R10", "hdr_addr idle", hdr_addr, 16'h014B);

        // R2 licensee forms, title sum hits entry 5 (direct)
        run_case(8'h01, 8'h00, 8'h00, B_CSUM[5], "B", 1, 0, "R2");
        run_case(8'h33, 8'h30, 8'h31, B_CSUM[5], "B", 2, 0, "R2");
        run_case(8'h33, 8'h30, 8'h32, B_CSUM[5], "B", 3, 0, "R2");
        run_case(8'h33, 8'h31, 8'h31, B_CSUM[5], "B", 4, 0, "R2");
        run_case(8'h33, 8'h01, 8'h01, B_CSUM[5], "B", 5, 0, "R2");
        run_case(8'h00, 8'h30, 8'h31, B_CSUM[5], "B", 6, 0, "R2");
        run_case(8'h30, 8'h30, 8'h31, B_CSUM[5], "B", 7, 0, "R2");
        run_case(8'h02, 8'h00, 8'h00, B_CSUM[70], "D", 8, 0, "R2");

        // R4 / R5 sweep of every title sum
        for (int s = 0; s < 256; s++)
            run_case((s % 2) ? 8'h01 : 8'h33, 8'h30, 8'h31, 8'(s), "C", s, 0, "R4/R5");

        // R6 every index above 64 against every letter
        for (int i = 65; i < B_CSUM_N; i++)
            for (int l = 0; l < 26; l++)
                run_case(8'h01, 8'h00, 8'h00, B_CSUM[i], 8'(65 + l), i + l, 0, "R6");

        // R7 explicit logo IDs: 0x43 (idx 67 row 0), 0x58 (idx 74 row 1 via 'O')
        run_case(8'h01, 8'h00, 8'h00, B_CSUM[67], "A", 9, 0, "R7");
        run_case(8'h01, 8'h00, 8'h00, B_CSUM[74], "O", 10, 0, "R7");

        // R9 start during a run is ignored
        run_case(8'h01, 8'h00, 8'h00, B_CSUM[12], "B", 11, 1, "R9");
        run_case(8'h33, 8'h30, 8'h31, B_CSUM[78], "T", 12, 1, "R9");
        run_case(8'h01, 8'h00, 8'h00, B_CSUM[74], "O", 13, 1, "R9");

        finish_run();
    end
endmodule